// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block brings a processor out of power-up. It keeps a reset request asserted until the supply reports good and the clock synthesizer reports lock. It then holds reset for a short fixed settle interval. After reset is released, it reads two 32-bit start-up values from a boot memory over a 16-bit external bus. The first value is the initial stack pointer and the second is the initial program counter.

The boot memory sits behind a default chip-select. That chip-select assumes a 16-bit port and adds a fixed number of wait clocks to every access. Each 32-bit value therefore takes two reads, high half first, and the whole fetch takes four back-to-back reads. The sequencer flags completion with a one-clock pulse. It then keeps both values constant until power is lost.

The controller has five states. HOLD keeps reset asserted while lock is absent. SETTLE counts the post-lock reset interval. FETCH runs the four reads. DONE lasts one clock and raises the completion pulse. RUN is the idle state after boot. Its transitions are:

- HOLD→SETTLE when lock is present.
- SETTLE→FETCH when the settle count expires.
- SETTLE→HOLD or FETCH→HOLD when lock is lost.
- FETCH→DONE on the last clock of the fourth read.
- DONE→RUN unconditionally.
- Any state→HOLD asynchronously when `pwr_ok` falls.

Top module: `boot_vector_fetch`

## Requirements
- R1: `sys_rst` is 1 whenever `pwr_ok` is 0, and it stays 1 for as long as `clk_lock` is 0 before boot.
- R2: After `clk_lock` goes high in HOLD, `sys_rst` stays 1 for RST_CYCLES more clocks (default 4). It falls on clock edge RST_CYCLES+1, counted from the first edge that sees the lock, and the first read begins on that same edge.
- R3: Exactly four reads are made. `boot_cs_n` and `bus_rd_n` are both low (active-low) throughout all of them and high at every other time.
- R4: The reads use byte addresses 0, 2, 4 and 6, in that order. Each address is held for 1+WAIT_STATES clocks (default 4).
- R5: Read data is sampled on the last clock of each read. `init_sp` is {word at 0, word at 2} and `init_pc` is {word at 4, word at 6}, with the high half in bits 31:16.
- R6: `vec_done` is 1 for exactly one clock, on the clock that follows the last clock of the fourth read (edge 21 after lock with default parameters).
- R7: A low level on `pwr_ok` resets the block at once, without waiting for a clock edge. While `sys_rst` is 1, `init_sp` and `init_pc` read 0.
- R8: After `vec_done`, all outputs hold their values until `pwr_ok` falls. Changes on `clk_lock` and `bus_rdata` have no effect during this time.
- R9: If `clk_lock` is 0 on an edge in SETTLE or FETCH, then after that edge `sys_rst` is 1 and the bus is idle. The sequence then restarts from HOLD, and the first read after the restart uses address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_ok | input | 1 | Supply good; also the active-low asynchronous reset |
| clk_lock | input | 1 | Clock synthesizer locked |
| bus_rdata | input | 16 | Read data from the boot memory |
| sys_rst | output | 1 | Reset request to the system, active high |
| boot_cs_n | output | 1 | Boot chip-select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_addr | output | ADDR_W (24) | Byte address of the current read |
| init_sp | output | 32 | Assembled initial stack pointer |
| init_pc | output | 32 | Assembled initial program counter |
| vec_done | output | 1 | One-clock pulse when both values are valid |

## Verification
Every result is due a fixed number of edges after the clock that first sees `clk_lock`. With the default parameters these are:

- `sys_rst` falls on edge 5.
- Read k is driven on edges 5+4k through 8+4k.
- `vec_done` and the final values appear after edge 21.
- A lock loss in SETTLE or FETCH shows on `sys_rst` one edge later.

The bench changes inputs on falling edges and samples on the next falling edge after each counted rising edge. It compares every output against a table built from these edge numbers. The only exception is the loss of `pwr_ok`, which is checked a fraction of a cycle later because it takes effect without a clock.

// File: rtl/bvf_pkg.sv
package bvf_pkg;
    localparam int BUS_W         = 16;
    localparam int VEC_W         = 32;
    localparam int NUM_VEC       = 2;
    localparam int WORDS_PER_VEC = VEC_W / BUS_W;
    localparam int NUM_READS     = NUM_VEC * WORDS_PER_VEC;
    localparam int IDX_W         = $clog2(NUM_READS);

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_SETTLE,
        ST_FETCH,
        ST_DONE,
        ST_RUN
    } bvf_state_e;
endpackage

// File: rtl/bvf_settle.sv
module bvf_settle #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic cnt_en,
    output logic expired
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign expired = cnt_en && (cnt_q == CW'(RST_CYCLES - 1));

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            cnt_q <= '0;
        end else if (!cnt_en) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2: the count never runs past its terminal value
    a_r2_settle_bound: assert property (@(posedge clk) disable iff (!pwr_ok)
        cnt_q <= CW'(RST_CYCLES - 1));
endmodule

// File: rtl/bvf_bus_timer.sv
module bvf_bus_timer
    import bvf_pkg::*;
#(
    parameter int WAIT_STATES = 3
) (
    input  logic             clk,
    input  logic             pwr_ok,
    input  logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             beat_last,
    output logic             final_beat
);
    localparam int WCW = $clog2(WAIT_STATES + 1) + 1;

    logic [WCW-1:0] wcnt_q;
    logic [IDX_W-1:0] idx_q;

    assign idx        = idx_q;
    assign beat_last  = active && (wcnt_q == WCW'(WAIT_STATES));
    assign final_beat = beat_last && (idx_q == IDX_W'(NUM_READS - 1));

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            wcnt_q <= '0;
            idx_q  <= '0;
        end else if (!active) begin
            wcnt_q <= '0;
            idx_q  <= '0;
        end else if (beat_last) begin
            wcnt_q <= '0;
            idx_q  <= idx_q + IDX_W'(1);
        end else begin
            wcnt_q <= wcnt_q + WCW'(1);
        end
    end

    // R4: a read never outlasts its wait budget
    a_r4_wait_bound: assert property (@(posedge clk) disable iff (!pwr_ok)
        wcnt_q <= WCW'(WAIT_STATES));

    // R4: the address index is held through the wait clocks
    a_r4_index_held: assert property (@(posedge clk) disable iff (!pwr_ok)
        (active && wcnt_q != '0) |-> $stable(idx_q));
endmodule

// File: rtl/bvf_vec_asm.sv
module bvf_vec_asm
    import bvf_pkg::*;
(
    input  logic                            clk,
    input  logic                            pwr_ok,
    input  logic                            clr,
    input  logic                            cap,
    input  logic [IDX_W-1:0]                idx,
    input  logic [BUS_W-1:0]                rdata,
    output logic [NUM_VEC-1:0][VEC_W-1:0]   vec
);
    logic [NUM_READS-1:0][BUS_W-1:0] words_q;

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            words_q <= '0;
        end else if (clr) begin
            words_q <= '0;
        end else if (cap) begin
            words_q[idx] <= rdata;
        end
    end

    // Earlier reads land in the more significant halves
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        for (genvar k = 0; k < WORDS_PER_VEC; k++) begin : g_half
            assign vec[v][(WORDS_PER_VEC-1-k)*BUS_W +: BUS_W] =
                clr ? '0 : words_q[v*WORDS_PER_VEC + k];
        end
    end

    // R5: nothing is written while the clear is held
    a_r5_no_cap_in_clear: assert property (@(posedge clk) disable iff (!pwr_ok)
        clr |-> !cap);
endmodule

// File: rtl/boot_vector_fetch.sv
module boot_vector_fetch
    import bvf_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int WAIT_STATES = 3,
    parameter int RST_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              pwr_ok,
    input  logic              clk_lock,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic              sys_rst,
    output logic              boot_cs_n,
    output logic              bus_rd_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [VEC_W-1:0]  init_sp,
    output logic [VEC_W-1:0]  init_pc,
    output logic              vec_done
);
    bvf_state_e state_q, state_d;

    logic                          settle_done;
    logic                          fetching;
    logic [IDX_W-1:0]              rd_idx;
    logic                          beat_last;
    logic                          final_beat;
    logic [NUM_VEC-1:0][VEC_W-1:0] vecs;

    assign fetching = (state_q == ST_FETCH);

    bvf_settle #(.RST_CYCLES(RST_CYCLES)) i_settle (
        .clk     (clk),
        .pwr_ok  (pwr_ok),
        .cnt_en  (state_q == ST_SETTLE),
        .expired (settle_done)
    );

    bvf_bus_timer #(.WAIT_STATES(WAIT_STATES)) i_timer (
        .clk        (clk),
        .pwr_ok     (pwr_ok),
        .active     (fetching),
        .idx        (rd_idx),
        .beat_last  (beat_last),
        .final_beat (final_beat)
    );

    bvf_vec_asm i_asm (
        .clk    (clk),
        .pwr_ok (pwr_ok),
        .clr    (sys_rst),
        .cap    (beat_last),
        .idx    (rd_idx),
        .rdata  (bus_rdata),
        .vec    (vecs)
    );

    assign init_sp = vecs[0];
    assign init_pc = vecs[1];

    // State register
    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) state_q <= ST_HOLD;
        else         state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   if (clk_lock) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!clk_lock)        state_d = ST_HOLD;
                else if (settle_done) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (!clk_lock)       state_d = ST_HOLD;
                else if (final_beat) state_d = ST_DONE;
            end
            ST_DONE:   state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        sys_rst   = 1'b0;
        boot_cs_n = 1'b1;
        bus_rd_n  = 1'b1;
        vec_done  = 1'b0;
        bus_addr  = '0;
        unique case (state_q)
            ST_HOLD, ST_SETTLE: sys_rst = 1'b1;
            ST_FETCH: begin
                boot_cs_n = 1'b0;
                bus_rd_n  = 1'b0;
                bus_addr  = {{(ADDR_W-IDX_W-1){1'b0}}, rd_idx, 1'b0};
            end
            ST_DONE:  vec_done = 1'b1;
            ST_RUN:   ;
        endcase
    end

    // R2: the first bus access after reset release targets address 0
    a_r2_first_read: assert property (@(posedge clk) disable iff (!pwr_ok)
        $fell(sys_rst) |-> (!boot_cs_n && bus_addr == '0));

    // R6: completion is a single-clock pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!pwr_ok)
        vec_done |=> !vec_done);

    // R8: boot values frozen once running
    a_r8_values_hold: assert property (@(posedge clk) disable iff (!pwr_ok)
        (state_q == ST_RUN) |=> ($stable(init_sp) && $stable(init_pc) && !sys_rst));

    // R9: losing lock mid-sequence re-enters reset with an idle bus
    a_r9_lock_drop: assert property (@(posedge clk) disable iff (!pwr_ok)
        ((state_q == ST_SETTLE || fetching) && !clk_lock) |=> (sys_rst && boot_cs_n));
endmodule

// File: tb/test_boot_vector_fetch.sv
module test_boot_vector_fetch;
    logic        clk = 1'b0;
    logic        pwr_ok = 1'b0;
    logic        clk_lock = 1'b0;
    logic [15:0] bus_rdata;
    logic        sys_rst, boot_cs_n, bus_rd_n, vec_done;
    logic [23:0] bus_addr;
    logic [31:0] init_sp, init_pc;

    logic [15:0] mem [4];
    int n_tot  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign bus_rdata = (!boot_cs_n && !bus_rd_n) ? mem[bus_addr[2:1]] : 16'h0000;

    boot_vector_fetch i_boot_vector_fetch (
        .clk       (clk),
        .pwr_ok    (pwr_ok),
        .clk_lock  (clk_lock),
        .bus_rdata (bus_rdata),
        .sys_rst   (sys_rst),
        .boot_cs_n (boot_cs_n),
        .bus_rd_n  (bus_rd_n),
        .bus_addr  (bus_addr),
        .init_sp   (init_sp),
        .init_pc   (init_pc),
        .vec_done  (vec_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Starts in HOLD with lock low; raises lock and checks edges 1..22
    task automatic run_boot(input string tag);
        logic [31:0] esp, epc;
        esp = {mem[0], mem[1]};
        epc = {mem[2], mem[3]};
        @(negedge clk);
        clk_lock = 1'b1;
        for (int n = 1; n <= 22; n++) begin
            logic f;
            @(negedge clk);
            f = (n >= 5) && (n <= 20);
            chk({tag, " R2 sys_rst"}, 64'(sys_rst), 64'(n <= 4));
            chk({tag, " R3 boot_cs_n"}, 64'(boot_cs_n), 64'(!f));
            chk({tag, " R3 bus_rd_n"}, 64'(bus_rd_n), 64'(!f));
            if (f) chk({tag, " R4 bus_addr"}, 64'(bus_addr), 64'(2 * ((n - 5) / 4)));
            chk({tag, " R6 vec_done"}, 64'(vec_done), 64'(n == 21));
            if (n >= 21) begin
                chk({tag, " R5 init_sp"}, 64'(init_sp), 64'(esp));
                chk({tag, " R5 init_pc"}, 64'(init_pc), 64'(epc));
            end
        end
    endtask

    task automatic t_reset_hold();
        pwr_ok = 1'b0;
        clk_lock = 1'b0;
        #3;
        chk("R1 sys_rst power low", 64'(sys_rst), 64'd1);
        chk("R7 init_sp power low", 64'(init_sp), 64'd0);
        chk("R7 init_pc power low", 64'(init_pc), 64'd0);
        chk("R3 boot_cs_n power low", 64'(boot_cs_n), 64'd1);
        chk("R6 vec_done power low", 64'(vec_done), 64'd0);
        @(negedge clk);
        pwr_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R1 sys_rst without lock", 64'(sys_rst), 64'd1);
            chk("R3 boot_cs_n without lock", 64'(boot_cs_n), 64'd1);
        end
    endtask

    task automatic t_boot(input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] c, input logic [15:0] d, input string tag);
        mem[0] = a; mem[1] = b; mem[2] = c; mem[3] = d;
        run_boot(tag);
    endtask

    task automatic t_run_frozen();
        logic [31:0] sp0, pc0;
        sp0 = init_sp;
        pc0 = init_pc;
        mem[0] = 16'h5555; mem[1] = 16'hAAAA; mem[2] = 16'h0F0F; mem[3] = 16'hF0F0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            clk_lock = (i % 2 == 1);
            chk("R8 init_sp frozen", 64'(init_sp), 64'(sp0));
            chk("R8 init_pc frozen", 64'(init_pc), 64'(pc0));
            chk("R8 sys_rst stays low", 64'(sys_rst), 64'd0);
            chk("R8 bus idle", 64'(boot_cs_n), 64'd1);
            chk("R8 no second done", 64'(vec_done), 64'd0);
        end
        clk_lock = 1'b1;
    endtask

    task automatic t_power_drop();
        @(negedge clk);
        #2;
        pwr_ok = 1'b0;
        #1;
        chk("R7 async sys_rst", 64'(sys_rst), 64'd1);
        chk("R7 async init_sp cleared", 64'(init_sp), 64'd0);
        chk("R7 async init_pc cleared", 64'(init_pc), 64'd0);
        clk_lock = 1'b0;
        @(negedge clk);
        pwr_ok = 1'b1;
    endtask

    task automatic t_lock_loss_fetch();
        mem[0] = 16'h1111; mem[1] = 16'h2222; mem[2] = 16'h3333; mem[3] = 16'h4444;
        @(negedge clk);
        clk_lock = 1'b1;
        for (int n = 1; n <= 10; n++) @(negedge clk);
        chk("R9 mid-fetch precondition", 64'(boot_cs_n), 64'd0);
        clk_lock = 1'b0;
        @(negedge clk);
        chk("R9 sys_rst after lock loss", 64'(sys_rst), 64'd1);
        chk("R9 bus idle after lock loss", 64'(boot_cs_n), 64'd1);
        chk("R9 init_sp cleared", 64'(init_sp), 64'd0);
        mem[0] = 16'hCAFE; mem[1] = 16'hF00D; mem[2] = 16'h0000; mem[3] = 16'h0400;
        run_boot("R9 restart from fetch");
    endtask

    task automatic t_lock_loss_settle();
        pwr_ok = 1'b0;
        #1;
        pwr_ok = 1'b1;
        clk_lock = 1'b0;
        @(negedge clk);
        clk_lock = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clk_lock = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 sys_rst after settle loss", 64'(sys_rst), 64'd1);
            chk("R9 no read after settle loss", 64'(boot_cs_n), 64'd1);
        end
        mem[0] = 16'hFFFF; mem[1] = 16'h0000; mem[2] = 16'h8000; mem[3] = 16'h0001;
        run_boot("R9 restart from settle");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mem[i] = 16'h0;
        t_reset_hold();
        t_boot(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, "R5 boot A");
        t_run_frozen();
        t_power_drop();
        t_boot(16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, "R5 boot B");
        t_power_drop();
        t_lock_loss_fetch();
        t_lock_loss_settle();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    initial begin
        #1ms;
        n_tot++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end
endmodule